// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block sits between a processor's read port and a slower main memory and keeps a small copy of recently used memory blocks. Every processor address is cut into three fields: a word offset at the bottom, a block index in the middle and a set number at the top. Main memory is treated as a stack of cache-sized sets. Cache slot B may hold only block B of one of those sets. A tag store indexed by B records which set the slot currently holds and whether it holds anything at all.

A read request is looked up in the cycle it is accepted. On a hit the word comes out of the local data array one cycle later. On a miss the controller reads the whole block from main memory one word at a time, starting at word 0. It hands the requested word to the processor as soon as that word arrives and writes every word into the slot. When the last word has arrived it records the new set number and marks the slot valid. The controller refuses new requests while a fill is in progress. Two counters record how many accepted requests hit and how many missed, so the hit ratio can be read at the ports.

Top module: `dmc_ctrl`

## Requirements
- R1: The address field positions are fixed. With the default parameters the word offset is bits [1:0], the block index is bits [7:2] and the set number is bits [23:8]. Every main-memory read address issued during a fill is {request set, request block, word counter}.
- R2: An accepted request hits when the slot at its block index is valid and the stored set number equals its set field. Equality is taken over every set bit. A hit raises `cpu_rdy` for one cycle on the cycle after acceptance, with `cpu_hit`=1 and `cpu_rdata` taken from the data array.
- R3: An accepted request that misses fetches every word of its block from main memory, in word order 0,1,2,3. `mem_rd` stays high and `mem_addr` stays stable until each word is acknowledged by `mem_ack`.
- R4: On a miss, `cpu_rdy` rises in the cycle after the `mem_ack` that carries the requested word. At that point `cpu_hit`=0 and `cpu_rdata` equals that memory word.
- R5: A request is accepted only while `cpu_busy` is low. `cpu_busy` is high from the cycle after a miss is accepted until the cycle after the last word is acknowledged. Requests presented while `cpu_busy` is high are ignored: they give no response and change no counter.
- R6: After a fill, a request to the same set and block hits. A request to the same block index but another set misses and evicts the earlier set.
- R7: Reset clears every valid bit, so the first access to any block after reset misses. Reset also clears `cpu_rdy`, `cpu_busy`, `mem_rd` and both counters.
- R8: `hit_cnt` rises by one for each accepted hit, and `miss_cnt` rises by one for each accepted miss.
- R9: Each accepted request produces exactly one single-cycle `cpu_rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request from the processor |
| cpu_addr | input | ADDR_W | Read address |
| cpu_busy | output | 1 | Fill in progress; requests are not taken |
| cpu_rdy | output | 1 | One-cycle response strobe |
| cpu_hit | output | 1 | Response was served from the cache |
| cpu_rdata | output | DATA_W | Response data |
| mem_rd | output | 1 | Main-memory read request |
| mem_addr | output | ADDR_W | Main-memory word address |
| mem_ack | input | 1 | Main-memory data valid |
| mem_rdata | input | DATA_W | Main-memory read data |
| hit_cnt | output | CNT_W | Count of accepted hits |
| miss_cnt | output | CNT_W | Count of accepted misses |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 32-bit words, 4 words per block, 64 blocks and 16-bit counters. Its memory model answers after two wait cycles. This puts block indices 0 and 63 within reach, as well as set numbers 0 and 0xFFFF. It also covers a requested word at offset 3, which makes the processor response arrive only with the final word of the fill. The vectors include a conflict between two sets on one block index, the eviction that follows it, and a reset that invalidates a block that had been filled.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int BLK_W = 6,
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_idx,
  input  logic [SET_W-1:0] rd_set,
  output logic             lookup_hit,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic [SET_W-1:0] wr_set
);

  localparam int NBLK = 1 << BLK_W;

  logic [SET_W-1:0] tag_flat [NBLK];
  logic [NBLK-1:0]  vld_flat;
  logic [SET_W-1:0] sel_tag;
  logic             sel_vld;
  logic             set_eq;

  for (genvar i = 0; i < NBLK; i++) begin : g_entry
    logic             vld_r;
    logic [SET_W-1:0] tag_r;
    logic             we;

    assign we = wr_en && (wr_idx == BLK_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
      end else if (we) begin
        vld_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we) begin
        tag_r <= wr_set;
      end
    end

    assign tag_flat[i] = tag_r;
    assign vld_flat[i] = vld_r;
  end

  always_comb begin
    sel_tag    = tag_flat[rd_idx];
    sel_vld    = vld_flat[rd_idx];
    set_eq     = &(~(sel_tag ^ rd_set));
    lookup_hit = sel_vld & set_eq;
  end

  // R6: a written entry holds the new set and is valid on the next cycle
  a_r6_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_flat[$past(wr_idx)] && (tag_flat[$past(wr_idx)] == $past(wr_set))));

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/dmc_fill_fsm.sv
module dmc_fill_fsm
  import dmc_pkg::*;
#(
  parameter int WORD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_ack,
  output logic              fill_active,
  output logic [WORD_W-1:0] word_cnt,
  output logic              last_ack
);

  localparam logic [WORD_W-1:0] LAST_WORD = '1;

  fill_state_e       state_q, state_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    last_ack = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (start) begin
          state_d = FS_FILL;
          cnt_d   = '0;
        end
      end
      FS_FILL: begin
        if (mem_ack) begin
          cnt_d = cnt_q + WORD_W'(1);
          if (cnt_q == LAST_WORD) begin
            last_ack = 1'b1;
            state_d  = FS_IDLE;
          end
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fill_active = (state_q == FS_FILL);
  assign word_cnt    = cnt_q;

  // R5: a new fill is only started from the idle state
  a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !fill_active);

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WPB    = 4,
  parameter int NBLK   = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_busy,
  output logic              cpu_rdy,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);

  localparam int WORD_W = $clog2(WPB);
  localparam int BLK_W  = $clog2(NBLK);
  localparam int SET_W  = ADDR_W - BLK_W - WORD_W;
  localparam int IDX_W  = BLK_W + WORD_W;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  // Request field split (R1)
  logic [WORD_W-1:0] a_word;
  logic [BLK_W-1:0]  a_blk;
  logic [SET_W-1:0]  a_set;

  assign a_word = cpu_addr[WORD_W-1:0];
  assign a_blk  = cpu_addr[IDX_W-1:WORD_W];
  assign a_set  = cpu_addr[ADDR_W-1:IDX_W];

  logic              fill_active;
  logic [WORD_W-1:0] word_cnt;
  logic              last_ack;
  logic              lookup_hit;
  logic              accept, do_hit, do_miss, fwd, fill_wr;
  logic [DATA_W-1:0] arr_rdata;

  logic [SET_W-1:0]  req_set_q;
  logic [BLK_W-1:0]  req_blk_q;
  logic [WORD_W-1:0] req_word_q;

  logic              rdy_q, rdy_d;
  logic              hit_q, hit_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [CNT_W-1:0]  hcnt_q, hcnt_d, mcnt_q, mcnt_d;

  always_comb begin
    accept  = cpu_req && !fill_active;
    do_hit  = accept && lookup_hit;
    do_miss = accept && !lookup_hit;
    fill_wr = fill_active && mem_ack;
    fwd     = fill_wr && (word_cnt == req_word_q);
  end

  dmc_tag_store #(
    .BLK_W (BLK_W),
    .SET_W (SET_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (a_blk),
    .rd_set     (a_set),
    .lookup_hit (lookup_hit),
    .wr_en      (last_ack),
    .wr_idx     (req_blk_q),
    .wr_set     (req_set_q)
  );

  dmc_data_store #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_data (
    .clk     (clk),
    .wr_en   (fill_wr),
    .wr_idx  ({req_blk_q, word_cnt}),
    .wr_data (mem_rdata),
    .rd_idx  ({a_blk, a_word}),
    .rd_data (arr_rdata)
  );

  dmc_fill_fsm #(
    .WORD_W (WORD_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (do_miss),
    .mem_ack     (mem_ack),
    .fill_active (fill_active),
    .word_cnt    (word_cnt),
    .last_ack    (last_ack)
  );

  // Miss capture: enabled register, no reset needed
  always_ff @(posedge clk) begin
    if (do_miss) begin
      req_set_q  <= a_set;
      req_blk_q  <= a_blk;
      req_word_q <= a_word;
    end
  end

  // Response and counter next state
  always_comb begin
    rdy_d   = do_hit || fwd;
    hit_d   = do_hit;
    rdata_d = do_hit ? arr_rdata : mem_rdata;
    hcnt_d  = do_hit  ? hcnt_q + CNT_ONE : hcnt_q;
    mcnt_d  = do_miss ? mcnt_q + CNT_ONE : mcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      hit_q  <= 1'b0;
      hcnt_q <= '0;
      mcnt_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      hit_q  <= hit_d;
      hcnt_q <= hcnt_d;
      mcnt_q <= mcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rdy_d) begin
      rdata_q <= rdata_d;
    end
  end

  assign cpu_busy  = fill_active;
  assign cpu_rdy   = rdy_q;
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;
  assign mem_rd    = fill_active;
  assign mem_addr  = {req_set_q, req_blk_q, word_cnt};
  assign hit_cnt   = hcnt_q;
  assign miss_cnt  = mcnt_q;

  // R2: a lookup hit answers on the next cycle, flagged as a hit
  a_r2_hit_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy && lookup_hit) |=> (cpu_rdy && cpu_hit));

  // R4: the memory word matching the request is forwarded next cycle
  a_r4_fwd_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack && (mem_addr[WORD_W-1:0] == req_word_q))
      |=> (cpu_rdy && !cpu_hit && (cpu_rdata == $past(mem_rdata))));

  // R3: a pending memory read holds its address until acknowledged
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  // R5: a request during a fill changes no counter
  a_r5_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_busy) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

endmodule

// File: tb/dmc_ctrl_tb_top.sv
module dmc_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam int NVEC       = 10;

  // {expected hit, address}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 24'h000010},  // set 0 blk 4 w0: cold miss
    {1'b1, 24'h000013},  // same block w3: hit
    {1'b1, 24'h000011},  // same block w1: hit
    {1'b0, 24'h010010},  // set 0x100 blk 4: conflict miss
    {1'b0, 24'h000012},  // set 0 blk 4 again: evicted, miss
    {1'b0, 24'h0000FF},  // blk 63 w3: miss, word forwarded last
    {1'b1, 24'h0000FC},  // blk 63 w0: hit
    {1'b0, 24'hFFFF02},  // top set, blk 0: miss
    {1'b1, 24'hFFFF01},  // hit
    {1'b0, 24'h000001}   // set 0 blk 0: evicts top set
  };

  logic        clk, rst_n;
  logic        cpu_req;
  logic [23:0] cpu_addr;
  logic        cpu_busy, cpu_rdy, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_rd, mem_ack;
  logic [23:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [15:0] hit_cnt, miss_cnt;

  int n_chk, n_fail;
  int lat_cnt;
  int fetch_n;
  logic [23:0] fetch_log [8];

  dmc_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_busy  (cpu_busy),
    .cpu_rdy   (cpu_rdy),
    .cpu_hit   (cpu_hit),
    .cpu_rdata (cpu_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .hit_cnt   (hit_cnt),
    .miss_cnt  (miss_cnt)
  );

  function automatic logic [31:0] pat(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Main-memory model: answers each read after MEM_LAT wait cycles
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    lat_cnt   = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_rd) begin
        if (lat_cnt == MEM_LAT) begin
          mem_ack   = 1'b1;
          mem_rdata = pat(mem_addr);
          if (fetch_n < 8) fetch_log[fetch_n] = mem_addr;
          fetch_n++;
          lat_cnt = 0;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic access(input logic [23:0] a, input bit exp_hit);
    int t;
    int exp_t;
    bit order_ok;
    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_addr = a;
    fetch_n  = 0;
    @(negedge clk);
    cpu_req = 1'b0;
    t = 1;
    while (!cpu_rdy && t < 200) begin
      @(negedge clk);
      t++;
    end
    exp_t = exp_hit ? 1 : int'(a[1:0]) * (MEM_LAT + 1) + MEM_LAT + 2;
    if (exp_hit) begin
      check(t == exp_t, "R2", "hit latency", t, exp_t);
      check(cpu_hit == 1'b1, "R2 R6", "hit flag", cpu_hit, 1);
      check(cpu_rdata == pat(a), "R2", "hit data", cpu_rdata, pat(a));
    end else begin
      check(t == exp_t, "R4", "miss latency", t, exp_t);
      check(cpu_hit == 1'b0, "R4 R6", "miss flag", cpu_hit, 0);
      check(cpu_rdata == pat(a), "R4", "forwarded data", cpu_rdata, pat(a));
    end
    @(negedge clk);
    check(cpu_rdy == 1'b0, "R9", "single pulse", cpu_rdy, 0);
    while (cpu_busy) @(negedge clk);
    if (!exp_hit) begin
      check(fetch_n == 4, "R3", "words fetched", fetch_n, 4);
      order_ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (fetch_log[i] != {a[23:2], 2'(i)}) order_ok = 1'b0;
      end
      check(order_ok, "R1 R3", "fetch address order", fetch_log[0], {a[23:2], 2'b00});
    end else begin
      check(fetch_n == 0, "R2", "no memory read on hit", fetch_n, 0);
    end
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    fetch_n  = 0;
    rst_n    = 1'b0;
    cpu_req  = 1'b0;
    cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: idle state after reset
    check(cpu_rdy == 1'b0 && cpu_busy == 1'b0 && mem_rd == 1'b0, "R7", "idle outputs",
          {cpu_rdy, cpu_busy, mem_rd}, 0);
    check(hit_cnt == 0 && miss_cnt == 0, "R7", "counters cleared", {hit_cnt, miss_cnt}, 0);

    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][23:0], VEC[v][24]);
    end

    // R8: 4 hits and 6 misses in the table
    check(hit_cnt == 16'd4, "R8", "hit count", hit_cnt, 4);
    check(miss_cnt == 16'd6, "R8", "miss count", miss_cnt, 6);

    // R5: requests during a fill are ignored (0x000013 would otherwise hit)
    begin
      logic [15:0] h0, m0;
      int t;
      int rdy_seen;
      h0 = hit_cnt;
      m0 = miss_cnt;
      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = 24'h000229;
      fetch_n  = 0;
      @(negedge clk);
      check(cpu_busy == 1'b1, "R5", "busy after miss", cpu_busy, 1);
      cpu_addr = 24'h000013;
      @(negedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      rdy_seen = 0;
      t = 0;
      while ((cpu_busy || cpu_rdy) && t < 200) begin
        if (cpu_rdy) begin
          rdy_seen++;
          check(cpu_rdata == pat(24'h000229) && !cpu_hit, "R5", "response belongs to fill",
                cpu_rdata, pat(24'h000229));
        end
        @(negedge clk);
        t++;
      end
      check(rdy_seen == 1, "R5 R9", "responses during fill", rdy_seen, 1);
      check(hit_cnt == h0, "R5", "hit count unchanged", hit_cnt, h0);
      check(miss_cnt == m0 + 16'd1, "R5 R8", "one miss counted", miss_cnt, m0 + 16'd1);
    end

    access(24'h000013, 1'b1);

    // R7: reset mid-run invalidates the filled block
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit_cnt == 0 && miss_cnt == 0, "R7", "counters after reset", {hit_cnt, miss_cnt}, 0);
    access(24'h000013, 1'b0);
    check(miss_cnt == 16'd1 && hit_cnt == 16'd0, "R7 R8", "post-reset access missed",
          {hit_cnt, miss_cnt}, 1);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

endmodule